// File: doc/BRIEF.md
# Centred-Sampling Serial Word Receiver

This block turns an asynchronous serial line into parallel words. The line idles high. Each frame opens with a low start bit. The payload follows, least significant bit first, then an optional parity bit, then one or two high stop bits. The frame format can be changed at run time through three configuration inputs, which must stay constant while a frame is in flight:

- payload length, from 5 to 8 bits;
- parity, which may be none, even or odd;
- number of stop bits.

A divisor input sets the bit period in clock cycles.

The raw line passes through a two-stage synchronizer. In idle, a falling edge on the synchronized line starts a frame. The receiver waits half a bit period and checks that the line is still low, which rejects noise pulses. It then samples once per full bit period, so each sample lands near the middle of its bit.

At the end of each frame the receiver gives one of these results:

- A good frame produces a single-cycle valid pulse, and the new word appears on the data output.
- A parity mismatch raises a single-cycle parity-error pulse.
- A low stop bit raises a single-cycle framing-error pulse instead of valid.

Top module: `sr_receiver`

## Requirements
- R1: While reset is low, all three pulse outputs are 0 and the word output is 0.
- R2: The line passes through two flip-flops. Start detection needs a high-to-low change of the synchronized line while idle. The start bit is sampled `divisor>>1` cycles after detection. If the line falls just before clock edge n+1, detection happens at edge n+3.
- R3: After the start sample, each later sample (data, parity, stop) is taken exactly `divisor` cycles after the previous one. Results appear on the outputs right after the edge that takes the last stop sample. The divisor must be at least 4.
- R4: The payload is assembled LSB first. The length code `cfg_len` is 0..3, meaning 5..8 bits. Word bits above the configured length are 0.
- R5: If the line is high at the start-bit sample, the receiver returns to idle and reports nothing.
- R6: Parity is set by the code `cfg_par`: 0 = none, 1 = even (data plus parity has an even count of ones), 2 = odd, and 3 = none. On a mismatch, `par_err_o` pulses at the frame end. If the stop bits are good, the word is still delivered with `word_vld_o`.
- R7: A stop bit sampled low makes `frm_err_o` pulse at the frame end. In that case `word_vld_o` stays 0 and `word_o` keeps its old value.
- R8: With `cfg_two_stop`=1, the frame has two stop periods and both must sample high. Failure of either one is a framing error, reported at the second stop sample.
- R9: Each pulse lasts exactly one cycle. `word_o` changes only at a valid pulse and holds its value otherwise.
- R10: `word_vld_o` and `frm_err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_i | input | 1 | Raw serial line, idle high |
| cfg_len | input | 2 | Payload length code (0..3 = 5..8 bits) |
| cfg_par | input | 2 | Parity code (0 none, 1 even, 2 odd, 3 none) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| divisor | input | DIV_W | Bit period in clock cycles (at least 4) |
| word_o | output | 8 | Last good received word |
| word_vld_o | output | 1 | One-cycle pulse for a good frame |
| par_err_o | output | 1 | One-cycle pulse on parity mismatch |
| frm_err_o | output | 1 | One-cycle pulse on a low stop bit |

## Verification
Suppose the bench drives the falling edge of a start bit just after clock edge n. Every result of that frame is then due at edge n + 3 + (divisor>>1) + k·divisor. Here k is the index of the final stop sample: the start bit is 0, the payload bits follow, then parity if enabled, then the stop bits.

The bench schedules each frame's expected pulses and word for that exact edge. On every clock it compares all four outputs against the schedule and requires silence on every other cycle. Because of this, a result that comes one cycle early or late is caught, and so is a pulse that is too long. Noise pulses and frames with bad stop bits are checked the same way: no valid pulse may appear, and the word output must not change.

// File: rtl/sr_rx_pkg.sv
// Shared types for the serial word receiver.
// Assumes payload lengths 5..8 selected by a 2-bit code.
package sr_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_t;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_OFF  = 2'd3
    } par_mode_t;

    localparam int MIN_BITS = 5;

    // Payload length in bits for a length code.
    function automatic logic [3:0] len_bits(input logic [1:0] code);
        return 4'(MIN_BITS) + {2'b00, code};
    endfunction

endpackage

// File: rtl/sr_rx_sync.sv
// Input synchronizer and falling-edge detector for the serial line.
// Assumes line_i is asynchronous; the chain resets to the idle level (1).
module sr_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw line through the flip-flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_i};
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign level_o = chain[STAGES-1];
    assign fall_o  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/sr_rx_timer.sv
// Bit-period cycle counter. Hit is high when the count equals limit_i.
// Assumes limit_i is stable between restarts; restart holds the count at 0.
module sr_rx_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic [W-1:0] cnt;

    assign hit_o = (cnt == limit_i);

    // Count cycles, wrapping to zero on a hit or a restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (restart_i | hit_o) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sr_rx_parity.sv
// Parity comparison for a received word.
// Assumes unused upper word bits are zero so they do not affect the sum.
module sr_rx_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] word_i,
    input  logic         pbit_i,
    input  logic [1:0]   mode_i,
    output logic         enabled_o,
    output logic         mismatch_o
);
    import sr_rx_pkg::*;

    logic want_odd;

    // Decode the mode and compare the total count of ones.
    always_comb begin
        enabled_o  = (mode_i == PAR_EVEN) || (mode_i == PAR_ODD);
        want_odd   = (mode_i == PAR_ODD);
        mismatch_o = enabled_o && ((^word_i ^ pbit_i) != want_odd);
    end
endmodule

// File: rtl/sr_receiver.sv
// Serial word receiver with centred sampling, parity and framing checks.
// Assumes divisor >= 4 and configuration inputs stable during a frame.
module sr_receiver #(
    parameter int DIV_W    = 16,
    parameter int MAX_BITS = 8,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic [1:0]       cfg_len,
    input  logic [1:0]       cfg_par,
    input  logic             cfg_two_stop,
    input  logic [DIV_W-1:0] divisor,
    output logic [7:0]       word_o,
    output logic             word_vld_o,
    output logic             par_err_o,
    output logic             frm_err_o
);
    import sr_rx_pkg::*;

    localparam int IDX_W = $clog2(MAX_BITS);

    rx_state_t            state;
    logic [IDX_W-1:0]     idx;
    logic [MAX_BITS-1:0]  shift;
    logic                 par_bit;
    logic                 stop_bad;
    logic                 line_s;
    logic                 fall;
    logic                 hit;
    logic [DIV_W-1:0]     limit;
    logic [3:0]           nbits;
    logic                 last_bit;
    logic                 par_on;
    logic                 par_mis;
    logic                 frame_end;
    logic                 end_bad;

    sr_rx_sync #(.STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_i),
        .level_o (line_s),
        .fall_o  (fall)
    );

    sr_rx_timer #(.W(DIV_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (state == ST_IDLE),
        .limit_i   (limit),
        .hit_o     (hit)
    );

    sr_rx_parity #(.W(MAX_BITS)) u_par (
        .word_i     (shift),
        .pbit_i     (par_bit),
        .mode_i     (cfg_par),
        .enabled_o  (par_on),
        .mismatch_o (par_mis)
    );

    // Pick the half-period wait for the start bit, a full period otherwise.
    always_comb begin
        if (state == ST_START) limit = (divisor >> 1) - 1'b1;
        else                   limit = divisor - 1'b1;
    end

    // Decode payload position and the end of a frame.
    always_comb begin
        nbits     = len_bits(cfg_len);
        last_bit  = ({{(4-IDX_W){1'b0}}, idx} == nbits - 4'd1);
        frame_end = hit && (((state == ST_STOP1) && !cfg_two_stop) ||
                            (state == ST_STOP2));
        end_bad   = (state == ST_STOP2) ? (stop_bad | ~line_s) : ~line_s;
    end

    // Frame sequencer: start check, payload, parity, stop bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            shift    <= '0;
            par_bit  <= 1'b0;
            stop_bad <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (fall) begin
                        state    <= ST_START;
                        idx      <= '0;
                        shift    <= '0;
                        par_bit  <= 1'b0;
                        stop_bad <= 1'b0;
                    end
                end
                ST_START: begin
                    if (hit) state <= line_s ? ST_IDLE : ST_DATA;
                end
                ST_DATA: begin
                    if (hit) begin
                        shift[idx] <= line_s;
                        if (last_bit) state <= par_on ? ST_PAR : ST_STOP1;
                        else          idx   <= idx + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (hit) begin
                        par_bit <= line_s;
                        state   <= ST_STOP1;
                    end
                end
                ST_STOP1: begin
                    if (hit) begin
                        if (cfg_two_stop) begin
                            stop_bad <= ~line_s;
                            state    <= ST_STOP2;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_STOP2: begin
                    if (hit) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result outputs: single-cycle pulses and the held word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o     <= '0;
            word_vld_o <= 1'b0;
            par_err_o  <= 1'b0;
            frm_err_o  <= 1'b0;
        end else begin
            word_vld_o <= frame_end && !end_bad;
            frm_err_o  <= frame_end && end_bad;
            par_err_o  <= frame_end && par_mis;
            if (frame_end && !end_bad) word_o <= 8'(shift);
        end
    end
endmodule

// File: rtl/sr_receiver_chk.sv
// Property checker for sr_receiver, attached with bind.
// Observes ports only; assumes configuration is stable during frames.
module sr_receiver_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cfg_len,
    input logic [1:0]       cfg_par,
    input logic [DIV_W-1:0] divisor,
    input logic [7:0]       word_o,
    input logic             word_vld_o,
    input logic             par_err_o,
    input logic             frm_err_o
);
    a_r9_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o);

    a_r9_ferr_single: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err_o |=> !frm_err_o);

    a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld_o |-> $stable(word_o));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_vld_o && frm_err_o));

    a_r4_short_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld_o && cfg_len == 2'd0) |-> (word_o[7:5] == 3'd0));

    a_r6_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_par == 2'd0 || cfg_par == 2'd3) |-> !par_err_o);

    a_r7_ferr_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err_o |-> $stable(word_o));
endmodule

bind sr_receiver sr_receiver_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_len    (cfg_len),
    .cfg_par    (cfg_par),
    .divisor    (divisor),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .par_err_o  (par_err_o),
    .frm_err_o  (frm_err_o)
);

// File: tb/tb_sr_receiver.sv
// Bench: drives frames, schedules expected results, compares every clock.
module tb_sr_receiver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_i = 1'b1;
    logic [1:0]  cfg_len = 2'd3;
    logic [1:0]  cfg_par = 2'd0;
    logic        cfg_two_stop = 1'b0;
    logic [15:0] divisor = 16'd16;
    logic [7:0]  word_o;
    logic        word_vld_o, par_err_o, frm_err_o;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    bit mon_on = 0;
    bit done = 0;

    int       ev_cyc[$];
    bit       ev_vld[$];
    bit       ev_perr[$];
    bit       ev_ferr[$];
    bit [7:0] ev_word[$];
    string    ev_tag[$];

    bit       exp_v, exp_p, exp_f;
    bit [7:0] exp_word = 8'h00;
    string    cur_tag;

    always #5 clk = ~clk;

    sr_receiver dut (
        .clk(clk), .rst_n(rst_n), .line_i(line_i),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop),
        .divisor(divisor), .word_o(word_o), .word_vld_o(word_vld_o),
        .par_err_o(par_err_o), .frm_err_o(frm_err_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Reference comparison on every clock.
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            exp_v = 0; exp_p = 0; exp_f = 0; cur_tag = "R9";
            if (ev_cyc.size() > 0 && ev_cyc[0] == cyc) begin
                exp_v = ev_vld.pop_front();
                exp_p = ev_perr.pop_front();
                exp_f = ev_ferr.pop_front();
                cur_tag = ev_tag.pop_front();
                if (exp_v) exp_word = ev_word[0];
                void'(ev_word.pop_front());
                void'(ev_cyc.pop_front());
            end
            checks++;
            if ({word_vld_o, par_err_o, frm_err_o} != {exp_v, exp_p, exp_f}) begin
                bad++;
                $display("FAIL %s cyc=%0d vld/perr/ferr act=%b%b%b exp=%b%b%b",
                         cur_tag, cyc, word_vld_o, par_err_o, frm_err_o,
                         exp_v, exp_p, exp_f);
            end
            checks++;
            if (word_o !== exp_word) begin
                bad++;
                $display("FAIL %s/R9 cyc=%0d word act=%h exp=%h",
                         cur_tag, cyc, word_o, exp_word);
            end
            checks++;
            if (word_vld_o && frm_err_o) begin
                bad++;
                $display("FAIL R10 cyc=%0d act=vld&ferr exp=exclusive", cyc);
            end
        end
    end

    task automatic send(input logic [7:0] data, input int nb, input int pm,
                        input bit two, input bit flip, input bit bs1,
                        input bit bs2, input int d, input string tag);
        int n;
        int last;
        bit pon;
        bit [7:0] m;
        @(negedge clk);
        cfg_len = 2'(nb - 5); cfg_par = 2'(pm); cfg_two_stop = two;
        divisor = 16'(d);
        repeat (2) @(negedge clk);
        m   = 8'hFF >> (8 - nb);
        pon = (pm == 1) || (pm == 2);
        last = nb + 1 + (pon ? 1 : 0) + (two ? 1 : 0);
        n = cyc;
        ev_cyc.push_back(n + 3 + d / 2 + last * d);
        ev_vld.push_back(!(bs1 || (two && bs2)));
        ev_ferr.push_back(bs1 || (two && bs2));
        ev_perr.push_back(pon && flip);
        ev_word.push_back(data & m);
        ev_tag.push_back(tag);
        line_i = 1'b0;
        repeat (d) @(negedge clk);
        for (int k = 0; k < nb; k++) begin
            line_i = data[k];
            repeat (d) @(negedge clk);
        end
        if (pon) begin
            line_i = (^(data & m)) ^ (pm == 2) ^ flip;
            repeat (d) @(negedge clk);
        end
        line_i = !bs1;
        repeat (d) @(negedge clk);
        if (two) begin
            line_i = !bs2;
            repeat (d) @(negedge clk);
        end
        line_i = 1'b1;
        repeat (2 * d) @(negedge clk);
    endtask

    task automatic glitch(input int width, input int d);
        @(negedge clk);
        divisor = 16'(d);
        line_i = 1'b0;
        repeat (width) @(negedge clk);
        line_i = 1'b1;
        repeat (3 * d) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++; // R1 reset state
        if ({word_o, word_vld_o, par_err_o, frm_err_o} !== 11'd0) begin
            bad++;
            $display("FAIL R1 act=%h/%b%b%b exp=0", word_o, word_vld_o,
                     par_err_o, frm_err_o);
        end
        rst_n = 1'b1;
        mon_on = 1;
        repeat (4) @(negedge clk);

        send(8'hA5, 8, 0, 0, 0, 0, 0, 16, "R2");
        send(8'h3C, 8, 0, 0, 0, 0, 0, 16, "R3");
        send(8'hF3, 5, 0, 0, 0, 0, 0, 16, "R4");
        send(8'h5A, 6, 0, 0, 0, 0, 0, 16, "R4");
        send(8'h41, 7, 1, 0, 0, 0, 0, 16, "R6");
        send(8'h96, 8, 2, 0, 1, 0, 0, 16, "R6");
        send(8'h17, 7, 1, 0, 1, 0, 0, 16, "R6");
        send(8'h22, 8, 3, 0, 0, 0, 0, 16, "R6");
        send(8'hC3, 8, 0, 0, 0, 1, 0, 16, "R7");
        send(8'h0F, 8, 1, 1, 1, 1, 0, 16, "R7");
        send(8'h81, 8, 0, 1, 0, 0, 0, 16, "R8");
        send(8'h7E, 8, 0, 1, 0, 0, 1, 16, "R8");
        glitch(3, 16);   // R5: short low pulse, no report expected
        glitch(6, 16);   // R5
        send(8'h2D, 6, 2, 0, 0, 0, 0, 9, "R3");
        send(8'hB4, 8, 1, 1, 0, 0, 0, 5, "R3");
        send(8'h66, 8, 0, 0, 0, 0, 0, 4, "R2");
        send(8'h99, 8, 2, 0, 0, 0, 0, 16, "R9");
        send(8'h99, 8, 2, 0, 0, 0, 0, 16, "R9");

        repeat (10) @(negedge clk);
        checks++;
        if (ev_cyc.size() != 0) begin
            bad++;
            $display("FAIL R3 pending results act=%0d exp=0", ev_cyc.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule